// File: doc/BRIEF.md
# Pin-Sequence Shutdown Detector

This block puts a serial-input converter into low-power shutdown and brings it back without using any command word. It watches the chip-select (active low) and serial-clock pins. Both pins are asynchronous, so the block first brings them into the system clock domain. Shutdown is requested by a pattern on these two pins: one level change on the serial clock, in either direction, followed by two falling edges on chip select. The serial clock must stay at one level between those two falling edges. Ordinary data frames never match this pattern, because the clock toggles between any two frames.

Once in shutdown, the block stays there for as long as the serial clock holds its level and chip select does not fall. Either of these counts as a wake-up: any serial-clock transition, or one chip-select fall. After a wake-up the block runs a recovery timer of about 50 µs before it reports the output as usable. The length of the timer is set from the system clock frequency. When the wake-up comes from a chip-select fall, the block raises an ignore flag until chip select returns high, so the load controller does not start a data frame on that edge.

Top module: `pin_shutdown_detect`

## Requirements
- R1: After reset, ready_o is 1, and shdn_o and frame_ignore_o are 0.
- R2: A serial-clock level change (rising or falling), followed by two cs_n_pin falling edges with no serial-clock change between them, sets shdn_o to 1 and ready_o to 0. The first of the two falls alone does not set shdn_o.
- R3: While in shutdown, with sclk_pin held steady and cs_n_pin not falling, shdn_o stays 1.
- R4: A serial-clock transition in either direction during shutdown clears shdn_o and keeps ready_o at 0 while recovery runs.
- R5: A single cs_n_pin falling edge during shutdown clears shdn_o.
- R6: After a wake-up, ready_o stays 0 with shdn_o 0 for exactly RECOVER_CYC system clock cycles, then returns to 1. RECOVER_CYC = CLK_FREQ_HZ / 1,000,000 × RECOVER_US.
- R7: A serial-clock change between the first and second cs_n_pin falls cancels the partial sequence. Two new cs_n_pin falls are then needed before shutdown is entered.
- R8: frame_ignore_o rises when a cs_n_pin fall wakes the block and stays 1 until cs_n_pin is high again. A serial-clock wake-up never raises it.
- R9: A wake-up event during recovery restarts the full RECOVER_CYC interval.
- R10: cs_n_pin falls with no preceding serial-clock change since the last return to ready do not enter shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip-select pin, active low, asynchronous |
| sclk_pin | input | 1 | Serial-clock pin, asynchronous |
| shdn_o | output | 1 | High while in low-power shutdown |
| ready_o | output | 1 | High when the output is valid, low during shutdown and recovery |
| frame_ignore_o | output | 1 | Tells the load controller to ignore the current chip-select window |

## Verification
The bench sweeps shutdown entry and exit over every combination of serial-clock direction and wake-up source. Each pass counts the recovery window cycle by cycle, so a timer that is off by one, or that skips recovery entirely, shows up as a wrong count. A design that does not drop a partial sequence on a clock change would enter shutdown one chip-select pulse too early. One that does not reload the timer on a second wake-up would raise ready while the restarted interval is still running. The bench also checks two further faults. A design that leaves the ignore flag off for chip-select wake-ups would let the next frame start on the wake-up edge. One that raises the flag for clock wake-ups would block frames that should go through.

// File: rtl/psd_pkg.sv
package psd_pkg;
   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_ARMED  = 3'd1,
      ST_ONE_CS = 3'd2,
      ST_SHDN   = 3'd3,
      ST_WAKING = 3'd4
   } psd_state_e;

   function automatic int unsigned recover_cycles(input int unsigned freq_hz,
                                                  input int unsigned rec_us);
      return (freq_hz / 1000000) * rec_us;
   endfunction
endpackage

// File: rtl/psd_sync.sv
module psd_sync #(
   parameter int unsigned        WIDTH   = 2,
   parameter int unsigned        STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/psd_edge.sv
module psd_edge #(
   parameter int unsigned      WIDTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] =  lvl_i[b] & ~prev_q[b];
      assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
   end
endmodule

// File: rtl/psd_recovery_timer.sv
module psd_recovery_timer #(
   parameter int unsigned CYCLES = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);
   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= LOAD_VAL;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pin_shutdown_detect.sv
module pin_shutdown_detect
   import psd_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ = 50000000,
   parameter int unsigned RECOVER_US  = 50,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SCLK_IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_pin,
   input  logic sclk_pin,
   output logic shdn_o,
   output logic ready_o,
   output logic frame_ignore_o
);
   localparam int unsigned RECOVER_CYC = recover_cycles(CLK_FREQ_HZ, RECOVER_US);
   localparam logic [1:0]  PIN_RST     = {SCLK_IDLE, 1'b1};

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RECOVER_CYC < 1) begin : g_chk_rec
      $error("recovery interval must be at least one cycle");
   end

   logic [1:0] pins_s, rise_s, fall_s;
   logic       cs_fall, cs_rise, sclk_edge, wake_evt, tmr_load, tmr_done;
   psd_state_e state_q, state_d;
   logic       ign_q;

   psd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sclk_pin, cs_n_pin}),
      .sync_o  (pins_s)
   );

   psd_edge #(.WIDTH(2), .RST_VAL(PIN_RST)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pins_s),
      .rise_o (rise_s),
      .fall_o (fall_s)
   );

   assign cs_fall   = fall_s[0];
   assign cs_rise   = rise_s[0];
   assign sclk_edge = rise_s[1] | fall_s[1];
   assign wake_evt  = cs_fall | sclk_edge;

   psd_recovery_timer #(.CYCLES(RECOVER_CYC)) tmr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .done_o (tmr_done)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      unique case (state_q)
         ST_ACTIVE: if (sclk_edge) state_d = ST_ARMED;
         ST_ARMED: begin
            if (sclk_edge)    state_d = ST_ARMED;
            else if (cs_fall) state_d = ST_ONE_CS;
         end
         ST_ONE_CS: begin
            if (sclk_edge)    state_d = ST_ARMED;
            else if (cs_fall) state_d = ST_SHDN;
         end
         ST_SHDN: begin
            if (wake_evt) begin
               state_d  = ST_WAKING;
               tmr_load = 1'b1;
            end
         end
         ST_WAKING: begin
            if (wake_evt)      tmr_load = 1'b1;
            else if (tmr_done) state_d  = ST_ACTIVE;
         end
         default: state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_ACTIVE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ign_q <= 1'b0;
      else if (state_q == ST_SHDN && cs_fall) ign_q <= 1'b1;
      else if (cs_rise)                       ign_q <= 1'b0;
   end

   assign shdn_o         = (state_q == ST_SHDN);
   assign ready_o        = (state_q != ST_SHDN) && (state_q != ST_WAKING);
   assign frame_ignore_o = ign_q;
endmodule

// File: rtl/pin_shutdown_detect_chk.sv
module pin_shutdown_detect_chk (
   input logic clk,
   input logic rst_n,
   input logic sclk_edge,
   input logic cs_fall,
   input logic cs_rise,
   input logic shdn_o,
   input logic ready_o,
   input logic frame_ignore_o
);
   AST_ENTRY_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shdn_o) |-> $past(cs_fall)); // R2
   AST_HOLD_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_o && !sclk_edge && !cs_fall |=> shdn_o); // R3
   AST_SCLK_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_o && sclk_edge |=> !shdn_o && !ready_o); // R4
   AST_CS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_o && cs_fall |=> !shdn_o && frame_ignore_o); // R5
   AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shdn_o) |-> !ready_o); // R6
   AST_IGNORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !frame_ignore_o); // R8
endmodule

bind pin_shutdown_detect pin_shutdown_detect_chk chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .sclk_edge      (sclk_edge),
   .cs_fall        (cs_fall),
   .cs_rise        (cs_rise),
   .shdn_o         (shdn_o),
   .ready_o        (ready_o),
   .frame_ignore_o (frame_ignore_o)
);

// File: tb/pin_shutdown_detect_tb_top.sv
module pin_shutdown_detect_tb_top;
   localparam int unsigned FREQ = 2000000;
   localparam int unsigned RUS  = 8;
   localparam int          RC   = (FREQ / 1000000) * RUS;

   logic clk = 1'b0;
   logic rst_n, cs_n, sclk;
   logic shdn, ready, ign;
   int   total = 0, bad = 0;

   always #10 clk = ~clk;

   pin_shutdown_detect #(.CLK_FREQ_HZ(FREQ), .RECOVER_US(RUS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk),
      .shdn_o(shdn), .ready_o(ready), .frame_ignore_o(ign));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tog_sclk();
      sclk = ~sclk;
      step(6);
   endtask

   task automatic cs_pulse();
      cs_n = 1'b0; step(6);
      cs_n = 1'b1; step(6);
   endtask

   // counts cycles with shutdown clear and ready low, until ready returns
   task automatic count_recovery(output int cnt, output bit ign_seen);
      cnt = 0; ign_seen = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (ign) ign_seen = 1'b1;
         if (!shdn && !ready) cnt++;
         if (ready) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int cnt;
      bit seen;
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0;
      step(4); rst_n = 1'b1; step(3);
      check(ready == 1'b1, "R1 ready", ready, 1);
      check(shdn == 1'b0,  "R1 shdn", shdn, 0);
      check(ign == 1'b0,   "R1 ignore", ign, 0);

      // R10: chip-select pulses with no clock change
      cs_pulse(); cs_pulse(); cs_pulse();
      check(shdn == 1'b0, "R10 no entry without clock change", shdn, 0);

      // sweep: clock direction x wake source
      for (int it = 0; it < 4; it++) begin
         bit by_cs = it[1];
         if (it[0]) tog_sclk();
         tog_sclk();
         cs_pulse();
         check(shdn == 1'b0, "R2 one fall not enough", shdn, 0);
         cs_pulse();
         check(shdn == 1'b1, "R2 entry", shdn, 1);
         check(ready == 1'b0, "R2 ready low", ready, 0);
         step(40);
         check(shdn == 1'b1, "R3 hold", shdn, 1);
         if (by_cs) cs_n = 1'b0;
         else       sclk = ~sclk;
         count_recovery(cnt, seen);
         check(shdn == 1'b0, by_cs ? "R5 cs wake" : "R4 sclk wake", shdn, 0);
         check(cnt == RC, "R6 recovery length", cnt, RC);
         if (by_cs) begin
            check(ign == 1'b1, "R8 ignore while cs low", ign, 1);
            cs_n = 1'b1; step(6);
            check(ign == 1'b0, "R8 ignore cleared", ign, 0);
         end else begin
            check(seen == 1'b0, "R8 no ignore on clock wake", seen, 0);
         end
      end

      // R7: clock change between falls restarts detection
      tog_sclk(); cs_pulse(); tog_sclk(); cs_pulse();
      check(shdn == 1'b0, "R7 gap clock change cancels", shdn, 0);
      cs_pulse();
      check(shdn == 1'b1, "R7 fresh pair enters", shdn, 1);

      // R9: second wake during recovery restarts the timer
      sclk = ~sclk; step(8);
      sclk = ~sclk; step(12);
      check(ready == 1'b0, "R9 restart holds ready low", ready, 0);
      step(12);
      check(ready == 1'b1, "R9 ready after restarted interval", ready, 1);

      // R10 again: ready state after recovery, no fresh clock change
      cs_pulse(); cs_pulse();
      check(shdn == 1'b0, "R10 no entry after recovery", shdn, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule